// File: doc/BRIEF.md
# Prescaled Reloading Interval Timer

This block is a programmable interval timer that raises a periodic interrupt. A down-counter of `CNT_W` bits (16 by default) steps down by one on every prescaled tick. An 8-bit scale value sets how many clock cycles make up one tick. When a tick takes the counter to zero, the block pulses its interrupt output for one cycle. The tick after that refills the counter from a separate period register.

Software programs the timer through a write-only register port. Each write carries a 2-bit register address and a data word. Behind the port sit the live count, the period used on refill, the scale value and an enable bit. The live count is visible at an output so that the counter state can be watched. Interrupt priority, masking and power management belong to other blocks.

Top module: `interval_timer`

## Requirements
- R1: After reset the count is 0, the period is 0, the scale is 0, the timer is disabled and `irq` is low.
- R2: A write happens on a clock edge where `wr_en` is high. The register is chosen by `wr_addr`: 0 is the count, 1 is the period, 2 is the scale (taken from `wr_data[7:0]`), and 3 is control, where `wr_data[0]` is the enable bit.
- R3: While enabled, with scale value S, a tick happens once every S+1 clock cycles. With S = 0 there is a tick on every cycle.
- R4: A tick when the count is nonzero lowers the count by one. When this takes the count to zero, `irq` is high for exactly the one cycle in which `count_o` first shows 0.
- R5: A tick when the count is zero loads the count from the period register.
- R6: When the period is 0, every tick raises a one-cycle `irq` and the count stays at 0.
- R7: A write to the count loads the written value and restarts the prescaler from zero. In that cycle the write wins over any tick.
- R8: A write to the period leaves the live count unchanged. The new period is used only at the next refill.
- R9: While disabled, the count and the prescaler keep their values and `irq` stays low. When the timer is enabled again, the prescaler resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 count, 1 period, 2 scale, 3 control |
| wr_data | input | CNT_W | Write data |
| irq | output | 1 | One-cycle interrupt pulse |
| count_o | output | CNT_W | Live count value |

## Verification
A register write takes effect at the clock edge that samples it. A tick moves `count_o` at that same edge, and `irq` rises in the same cycle in which `count_o` shows 0. After reset, the first tick happens on the (S+1)-th enabled edge counted from the last count write.

The bench drives inputs on falling edges and also samples on falling edges. So every result is read half a cycle after the edge that produced it. From the scale value it works out how many edges each expected count needs. It tallies `irq` on every falling edge, which shows that each pulse lasts exactly one cycle and lines up with a zero count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned TMR_AW = 2;

    typedef enum logic [TMR_AW-1:0] {
        REG_COUNT  = 2'd0,
        REG_PERIOD = 2'd1,
        REG_SCALE  = 2'd2,
        REG_CTRL   = 2'd3
    } tmr_reg_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SCL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TMR_AW-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  period,
    output logic [SCL_W-1:0]  scale,
    output logic              run,
    output logic              load,
    output logic [CNT_W-1:0]  load_val
);
    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [SCL_W-1:0] scale;
        logic             run;
    } regs_t;

    regs_t    r_q, r_d;
    tmr_reg_e sel;

    assign sel = tmr_reg_e'(wr_addr);

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (sel)
                REG_PERIOD: r_d.period = wr_data;
                REG_SCALE:  r_d.scale  = wr_data[SCL_W-1:0];
                REG_CTRL:   r_d.run    = wr_data[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign period   = r_q.period;
    assign scale    = r_q.scale;
    assign run      = r_q.run;
    assign load     = wr_en && (sel == REG_COUNT);
    assign load_val = wr_data;

    AST_PERIOD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_PERIOD) |=> (period == $past(wr_data))); // R2
    AST_PERIOD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == REG_PERIOD) |=> $stable(period)); // R8
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SCL_W-1:0] scale,
    output logic             tick
);
    typedef struct packed {
        logic [SCL_W-1:0] pre;
    } pre_t;

    pre_t pre_q, pre_d;
    logic at_limit;

    assign at_limit = (pre_q.pre >= scale);

    always_comb begin
        pre_d = pre_q;
        if (restart) begin
            pre_d.pre = '0;
        end else if (run) begin
            if (at_limit) pre_d.pre = '0;
            else          pre_d.pre = pre_q.pre + SCL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = run && !restart && at_limit;

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run); // R9
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(pre_q)); // R9
    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q.pre == '0)); // R7
    AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !tick) |=> (pre_q.pre == $past(pre_q.pre) + SCL_W'(1))); // R3
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cnt_t;

    cnt_t c_q, c_d;

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        if (load) begin
            c_d.cnt = load_val;
        end else if (tick) begin
            if (c_q.cnt == '0) begin
                c_d.cnt = period;
                c_d.irq = (period == '0);
            end else begin
                c_d.cnt = c_q.cnt - CNT_W'(1);
                c_d.irq = (c_q.cnt == CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.cnt;
    assign irq   = c_q.irq;

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '0)); // R4
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count != '0) |=> (count == $past(count) - CNT_W'(1))); // R4
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count == '0) |=> (count == $past(period))); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val) && !irq)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> ($stable(count) && !irq)); // R9
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SCL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TMR_AW-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              irq,
    output logic [CNT_W-1:0]  count_o
);
    logic [CNT_W-1:0] period;
    logic [SCL_W-1:0] scale;
    logic             run;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             tick;

    tmr_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .period   (period),
        .scale    (scale),
        .run      (run),
        .load     (load),
        .load_val (load_val)
    );

    tmr_prescale #(.SCL_W(SCL_W)) i_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (load),
        .scale   (scale),
        .tick    (tick)
    );

    tmr_count #(.CNT_W(CNT_W)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .period   (period),
        .count    (count_o),
        .irq      (irq)
    );

    AST_ZERO_PERIOD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count_o == '0 && period == '0) |=> irq); // R6
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 8;

    localparam int V_S[NV]    = '{0, 0, 2, 3, 1, 0, 255, 4};
    localparam int V_P[NV]    = '{4, 4, 5, 0, 3, 2, 1, 10};
    localparam int V_C[NV]    = '{3, 3, 2, 1, 0, 5, 1, 20};
    localparam int V_N[NV]    = '{3, 10, 20, 17, 9, 4, 512, 34};
    localparam int V_ECNT[NV] = '{0, 3, 2, 0, 0, 1, 1, 14};
    localparam int V_EIRQ[NV] = '{1, 2, 1, 4, 1, 0, 1, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        irq;
    logic [15:0] count_o;

    int checks = 0;
    int fails  = 0;
    int irqs   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer i_interval_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq     (irq),
        .count_o (count_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Call just after a falling edge; returns just after the next one.
    task automatic wr(input logic [1:0] a, input int d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = 16'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Let n rising edges pass; tally irq; irq must coincide with a zero count (R4).
    task automatic run(input int n);
        irqs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq) begin
                irqs++;
                if (count_o != 16'd0) chk("R4 irq with zero count", int'(count_o), 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count after reset", int'(count_o), 0);
        chk("R1 irq after reset", int'(irq), 0);
        run(5);
        chk("R1 disabled after reset, count", int'(count_o), 0);
        chk("R1 disabled after reset, irq", irqs, 0);

        // Vector table: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            wr(2'd3, 0);
            wr(2'd2, V_S[v]);
            wr(2'd1, V_P[v]);
            wr(2'd0, V_C[v]);
            wr(2'd3, 1);
            run(V_N[v]);
            chk($sformatf("R3/R5 vector %0d count", v), int'(count_o), V_ECNT[v]);
            chk($sformatf("R4/R6 vector %0d irq pulses", v), irqs, V_EIRQ[v]);
        end

        // R9: hold while disabled; prescaler resumes
        wr(2'd3, 0);
        wr(2'd2, 5);
        wr(2'd1, 7);
        wr(2'd0, 4);
        wr(2'd3, 1);
        run(2);
        wr(2'd3, 0);
        run(10);
        chk("R9 count held while disabled", int'(count_o), 4);
        chk("R9 no irq while disabled", irqs, 0);
        wr(2'd3, 1);
        run(2);
        chk("R9 prescaler resumed, not yet ticked", int'(count_o), 4);
        run(1);
        chk("R9 prescaler resumed, ticked", int'(count_o), 3);

        // R8: period write leaves count alone, used at next refill
        wr(2'd3, 0);
        wr(2'd2, 0);
        wr(2'd1, 3);
        wr(2'd0, 5);
        wr(2'd3, 1);
        run(1);
        chk("R8 count before period write", int'(count_o), 4);
        wr(2'd1, 9);
        chk("R8 count after period write", int'(count_o), 3);
        run(3);
        chk("R4 count reaches zero", int'(count_o), 0);
        chk("R4 one irq at zero", irqs, 1);
        run(1);
        chk("R8 refill uses new period", int'(count_o), 9);

        // R7: count write restarts prescaler and wins over tick
        wr(2'd3, 0);
        wr(2'd2, 3);
        wr(2'd0, 10);
        wr(2'd3, 1);
        run(2);
        wr(2'd0, 6);
        run(3);
        chk("R7 prescaler restarted", int'(count_o), 6);
        run(1);
        chk("R7 first tick after restart", int'(count_o), 5);
        wr(2'd2, 0);
        run(1);
        wr(2'd0, 6);
        chk("R7 write wins over tick", int'(count_o), 6);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule